// File: doc/BRIEF.md
# 64-bit Bitwise and Shift Unit

This block is a purely combinational 64-bit logic unit. A 4-bit variant code picks one of thirteen operations applied to two operands, `y` and `z`. The operations are logical shifts in both directions, an arithmetic right shift, rotates in both directions, copy and invert of `y`, and the six two-input Boolean functions. The result appears on `result` in the same cycle.

The unit sits in an execute stage, where a decoder places the operation's variant code on `variant`. Shift and rotate distances come from the low six bits of `z`. The rest of `z` is ignored for those operations. Codes 13 to 15 are not assigned. For these codes the unit returns zero and drops `valid`, so the surrounding pipeline can flag an illegal operation.

Top module: `bitlogic_unit`

## Requirements
- R1: With variant 0, `result` is `y` shifted left by `z[5:0]` bits, with zeros filling the vacated positions.
- R2: With variant 1, `result` is `y` shifted right by `z[5:0]` bits, with zeros filling the vacated upper positions.
- R3: With variant 2, `result` is `y` shifted right by `z[5:0]` bits, with copies of `y[63]` filling the vacated upper positions.
- R4: With variant 3, `result` is `y` rotated left by `z[5:0]` bits. With variant 4, `result` is `y` rotated right by `z[5:0]` bits.
- R5: For variants 0 to 4, bits `z[63:6]` have no effect on `result`. For example, z = 64 acts as a count of zero and z = 65 acts as a count of one.
- R6: For variants 0 to 4, a count `z[5:0]` of zero gives `result` equal to `y`.
- R7: Variant 5 gives `result = y` and variant 6 gives `result = ~y`. In both cases `z` has no effect.
- R8: Variants 7, 8 and 9 give `y | z`, `y & z` and `~(y & z)` respectively.
- R9: Variants 10, 11 and 12 give `~(y | z)`, `y ^ z` and `~(y ^ z)` respectively.
- R10: Variants 13, 14 and 15 give `result = 0` and `valid = 0`, whatever `y` and `z` are.
- R11: `valid` is 1 for every variant from 0 to 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| y | input | 64 | First operand; the value that is shifted, rotated, copied or inverted |
| z | input | 64 | Second operand; its bits [5:0] give the shift or rotate count |
| variant | input | 4 | Operation select code, 0 to 15 |
| result | output | 64 | Operation result |
| valid | output | 1 | High when `variant` names one of the thirteen defined operations |

## Verification
Two rules can apply to the same input. The first is that a count of zero passes `y` through unchanged. The second is that `z` above bit 5 is ignored. Both apply together when `z` is a nonzero multiple of 64. The bench drives z = 64, z = 128 and all-ones-above-bit-5 patterns on every shift and rotate variant, with a negative `y` so that the arithmetic fill would be visible if the count were misread. It then compares `result` with a bit-loop reference model. Random operands and codes then mix these corners with ordinary counts.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

  typedef enum logic [3:0] {
    OP_SHL   = 4'd0,
    OP_SHR   = 4'd1,
    OP_SAR   = 4'd2,
    OP_ROL   = 4'd3,
    OP_ROR   = 4'd4,
    OP_COPY  = 4'd5,
    OP_NOT   = 4'd6,
    OP_OR    = 4'd7,
    OP_AND   = 4'd8,
    OP_NAND  = 4'd9,
    OP_NOR   = 4'd10,
    OP_XOR   = 4'd11,
    OP_XNOR  = 4'd12
  } bl_op_e;

  localparam int unsigned LAST_OP = 12;

  // Truth table per op, indexed by {y_bit, z_bit}.
  function automatic logic [3:0] bool_table(input logic [3:0] code);
    logic [3:0] t;
    case (code)
      OP_COPY: t = 4'b1100;
      OP_NOT:  t = 4'b0011;
      OP_OR:   t = 4'b1110;
      OP_AND:  t = 4'b1000;
      OP_NAND: t = 4'b0111;
      OP_NOR:  t = 4'b0001;
      OP_XOR:  t = 4'b0110;
      OP_XNOR: t = 4'b1001;
      default: t = 4'b0000;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bitlogic_shift.sv
module bitlogic_shift
  import bitlogic_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned CW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] y,
  input  logic [CW-1:0]    amt,
  input  logic [3:0]       code,
  output logic [WIDTH-1:0] res
);

  logic [CW:0]        amt_comp;
  logic [WIDTH-1:0]   shl_v;
  logic [WIDTH-1:0]   shr_v;
  logic [WIDTH-1:0]   sar_v;
  logic [WIDTH-1:0]   rol_v;
  logic [WIDTH-1:0]   ror_v;

  // WIDTH - amt; equals WIDTH when amt is 0, which shifts everything out.
  assign amt_comp = (CW+1)'(WIDTH) - {1'b0, amt};

  assign shl_v = y << amt;
  assign shr_v = y >> amt;
  assign sar_v = WIDTH'($signed(y) >>> amt);
  assign rol_v = shl_v | (y >> amt_comp);
  assign ror_v = shr_v | (y << amt_comp);

  always_comb begin
    case (code)
      OP_SHL:  res = shl_v;
      OP_SHR:  res = shr_v;
      OP_SAR:  res = sar_v;
      OP_ROL:  res = rol_v;
      OP_ROR:  res = ror_v;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/bitlogic_bool.sv
module bitlogic_bool
  import bitlogic_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] z,
  input  logic [3:0]       code,
  output logic [WIDTH-1:0] res
);

  logic [3:0] tbl;

  assign tbl = bool_table(code);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign res[i] = tbl[{y[i], z[i]}];
    end
  endgenerate

endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
  import bitlogic_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned SEL_W = 4
) (
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] z,
  input  logic [SEL_W-1:0] variant,
  output logic [WIDTH-1:0] result,
  output logic             valid
);

  localparam int unsigned CW = $clog2(WIDTH);

  logic [3:0]       code;
  logic             is_shift;
  logic             is_bool;
  logic [WIDTH-1:0] shift_res;
  logic [WIDTH-1:0] bool_res;

  assign code     = 4'(variant);
  assign is_shift = (code <= 4'(OP_ROR));
  assign is_bool  = (code >= 4'(OP_COPY)) && (code <= 4'(LAST_OP));

  bitlogic_shift #(.WIDTH(WIDTH)) u_shift (
    .y    (y),
    .amt  (z[CW-1:0]),
    .code (code),
    .res  (shift_res)
  );

  bitlogic_bool #(.WIDTH(WIDTH)) u_bool (
    .y    (y),
    .z    (z),
    .code (code),
    .res  (bool_res)
  );

  always_comb begin
    valid  = is_shift | is_bool;
    result = '0;
    if (is_shift)     result = shift_res;
    else if (is_bool) result = bool_res;
  end

endmodule

// File: rtl/bitlogic_checker.sv
module bitlogic_checker #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned SEL_W = 4
) (
  input logic [WIDTH-1:0] y,
  input logic [WIDTH-1:0] z,
  input logic [SEL_W-1:0] variant,
  input logic [WIDTH-1:0] result,
  input logic             valid
);

  always_comb begin
    assert_unassigned_zero_R10: assert (!(variant > 12) || (result == '0 && !valid))
      else $error("R10: unassigned code gave nonzero result or valid");
    assert_valid_set_R11: assert (!(variant <= 12) || valid)
      else $error("R11: valid low for assigned code");
    assert_zero_count_R6: assert (!(variant <= 4 && z[5:0] == 6'd0) || result == y)
      else $error("R6: zero count changed y");
    assert_sign_fill_R3: assert (!(variant == 2 && y[WIDTH-1]) || result[WIDTH-1])
      else $error("R3: arithmetic shift lost sign");
    assert_nand_disjoint_R8: assert (!(variant == 9) || ((result & y & z) == '0))
      else $error("R8: nand overlaps and");
    assert_rot_popcount_R4: assert (!(variant == 3 || variant == 4) ||
                                    $countones(result) == $countones(y))
      else $error("R4: rotate changed bit count");
  end

endmodule

bind bitlogic_unit bitlogic_checker #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_bitlogic_unit.sv
module sim_bitlogic_unit;

  logic        clk;
  logic        rst_n;
  logic [63:0] y;
  logic [63:0] z;
  logic [3:0]  variant;
  logic [63:0] result;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bitlogic_unit u0 (
    .y(y), .z(z), .variant(variant), .result(result), .valid(valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [3:0] v);
    logic [63:0] r;
    int n;
    n = int'(b[5:0]);
    r = '0;
    for (int i = 0; i < 64; i++) begin
      case (v)
        4'd0: r[i] = (i >= n) ? a[i-n] : 1'b0;
        4'd1: r[i] = (i + n < 64) ? a[i+n] : 1'b0;
        4'd2: r[i] = (i + n < 64) ? a[i+n] : a[63];
        4'd3: r[i] = a[(i - n + 64) % 64];
        4'd4: r[i] = a[(i + n) % 64];
        4'd5: r[i] = a[i];
        4'd6: r[i] = !a[i];
        4'd7: r[i] = a[i] || b[i];
        4'd8: r[i] = a[i] && b[i];
        4'd9: r[i] = !(a[i] && b[i]);
        4'd10: r[i] = !(a[i] || b[i]);
        4'd11: r[i] = a[i] != b[i];
        4'd12: r[i] = a[i] == b[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] v);
    case (v)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R7";
      4'd7, 4'd8, 4'd9: return "R8";
      4'd10, 4'd11, 4'd12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [3:0] v,
                       input string tag);
    logic [63:0] er;
    logic        ev;
    @(negedge clk);
    y = a; z = b; variant = v;
    #2;
    er = model(a, b, v);
    ev = (v <= 4'd12);
    checks++;
    if (result !== er || valid !== ev) begin
      errors++;
      $display("FAIL %s: v=%0d y=%h z=%h result=%h valid=%b expected %h valid=%b",
               tag, v, a, b, result, valid, er, ev);
    end
  endtask

  initial begin
    logic [63:0] ra, rb;
    logic [3:0]  rv;
    void'($urandom(32'd2024));
    rst_n = 1'b0; y = '0; z = '0; variant = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(64'h0, 64'h0, 4'd0, "R11 idle");
    // Directed shifts
    apply(64'h8000_0000_0000_0001, 64'd1, 4'd0, "R1");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 4'd0, "R1");
    apply(64'h8000_0000_0000_0001, 64'd1, 4'd1, "R2");
    apply(64'h8000_0000_0000_0000, 64'd63, 4'd1, "R2");
    apply(64'h8000_0000_0000_0000, 64'd63, 4'd2, "R3");
    apply(64'h7000_0000_0000_0000, 64'd4, 4'd2, "R3");
    apply(64'h8000_0000_0000_0001, 64'd1, 4'd3, "R4");
    apply(64'h8000_0000_0000_0001, 64'd1, 4'd4, "R4");
    apply(64'h0123_4567_89AB_CDEF, 64'd63, 4'd3, "R4");
    // Count zero and masked upper Z bits, on every shift and rotate
    for (int v = 0; v <= 4; v++) begin
      apply(64'hF0E1_D2C3_B4A5_9687, 64'd0, 4'(v), "R6");
      apply(64'hF0E1_D2C3_B4A5_9687, 64'd64, 4'(v), "R5 R6");
      apply(64'hF0E1_D2C3_B4A5_9687, 64'd128, 4'(v), "R5 R6");
      apply(64'hF0E1_D2C3_B4A5_9687, 64'd65, 4'(v), "R5");
      apply(64'hF0E1_D2C3_B4A5_9687, 64'hFFFF_FFFF_FFFF_FFC3, 4'(v), "R5");
    end
    // Unary and Boolean
    apply(64'hDEAD_BEEF_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 4'd5, "R7");
    apply(64'hDEAD_BEEF_0000_FFFF, 64'h1234_5678_9ABC_DEF0, 4'd6, "R7");
    for (int v = 7; v <= 12; v++)
      apply(64'hFF00_FF00_F0F0_CCAA, 64'hF0F0_FF00_AAAA_0F0F, 4'(v), (v <= 9) ? "R8" : "R9");
    // Unassigned codes
    for (int v = 13; v <= 15; v++) begin
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 4'(v), "R10");
      apply(64'h0123_4567_89AB_CDEF, 64'd3, 4'(v), "R10");
    end
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      rv = 4'($urandom_range(0, 15));
      if (k % 7 == 0) rb[5:0] = 6'd0;
      apply(ra, rb, rv, req_of(rv));
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule